// File: doc/BRIEF.md
# SCSI Controller Command Decoder

This block sits behind the register write port of a SCSI host controller. It watches byte writes to the command register, splits each command byte into a DMA-mode flag (bit 7) and a 7-bit opcode (bits 6:0), and applies the fixed side effects of that opcode to the status and interrupt registers. It also holds the transfer-count registers. Software writes the count bytes, and a command with the DMA flag set copies them into the readable copy.

The SCSI target engine and the DMA engine are outside the block. The decoder tells them what to do through one-cycle strobes: chip reset, transfer start, the three select variants and the status-response write. The DMA engine reports the end of a transfer through a single completion pulse. For a transfer command the block also presents the effective byte count, where a zero count stands for 65536 bytes.

Top module: `scsi_cmd_dec`

## Requirements
- R1: After rst_ni is released, and one cycle after the chip-reset opcode 0x02 (with or without the DMA flag), all of the following hold: status 0, interrupt 0, both count bytes 0, dma_mode_o 0, irq_o 0, xfer_len_o 0, the stored written counts 0 and the quiet bit 0. chip_rst_o pulses for that cycle.
- R2: A legal non-reset command with bit 7 set sets dma_mode_o and copies the written count bytes (address 0 low, address 1 mid) into cnt_lo_o/cnt_mid_o. Bit 7 clear clears dma_mode_o and leaves the counts unchanged.
- R3: A write to address 0 or 1 clears status bit 4 (terminal count) and does not change cnt_lo_o/cnt_mid_o.
- R4: Flush (0x01) sets the interrupt register to 0x08 and leaves irq_o unchanged.
- R5: Bus reset (0x03) sets the interrupt register to 0x80. It raises irq_o only when bit 6 of the last write to address 8 is 0.
- R6: Message accepted (0x12) sets the interrupt register to 0x20 and raises irq_o. Status bit 7 always equals irq_o.
- R7: Pad (0x18) sets status bits 6:0 to 0x10 and the interrupt register to 0x08.
- R8: Enable selection (0x44) clears the interrupt register.
- R9: Transfer information (0x10) pulses xfer_start_o and sets xfer_len_o to the 16-bit count {mid,low} taken after any DMA reload, with 0 giving 65536. With bit 7 set it clears status bit 4. Without bit 7 it leaves status bit 4 as it was.
- R10: Command-complete sequence (0x11) pulses resp_o, sets the interrupt register to 0x08 and sets status bits 2:0 to 7.
- R11: Opcodes 0x41, 0x42 and 0x43 pulse sel_o, sel_atn_o and sel_stop_o. Set ATN (0x1A) and no-op (0x00) change no status or interrupt bit and pulse no strobe.
- R12: An opcode outside the legal set pulses illegal_o and changes no register, DMA mode included.
- R13: A dma_done_i pulse sets status bit 4, sets the interrupt register to 0x10, clears both count bytes and raises irq_o.
- R14: Every strobe is high for exactly one cycle, in the cycle after the command write, and at most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 4 | Register address (0 count low, 1 count mid, 3 command, 8 config) |
| wr_data_i | input | 8 | Write data |
| dma_done_i | input | 1 | DMA transfer completion pulse |
| status_o | output | 8 | Status register (bit 7 interrupt, bit 4 terminal count, bits 2:0 phase) |
| intr_o | output | 8 | Interrupt cause register |
| cnt_lo_o | output | 8 | Readable transfer count, low byte |
| cnt_mid_o | output | 8 | Readable transfer count, mid byte |
| dma_mode_o | output | 1 | DMA mode of the last legal command |
| irq_o | output | 1 | Interrupt request |
| xfer_len_o | output | 17 | Effective length of the last transfer command |
| chip_rst_o | output | 1 | Chip reset strobe |
| xfer_start_o | output | 1 | Transfer start strobe |
| sel_o | output | 1 | Select without ATN strobe |
| sel_atn_o | output | 1 | Select with ATN strobe |
| sel_stop_o | output | 1 | Select with ATN and stop strobe |
| resp_o | output | 1 | Status-response write strobe |
| illegal_o | output | 1 | Unrecognised opcode strobe |

## Verification
Every opcode is issued from a known state after a chip reset, so each check tells one opcode's side effects apart from what the state already held. For transfer commands the test sends a nonzero count with the DMA flag, then a count rewritten to zero without the flag, then zero with the flag. These three cases separate the reload path, the stale readable copy and the 65536 substitution. Bus reset runs once with the quiet bit clear and once with it set. Terminal count is first set by pad and then cleared by a count write or a DMA transfer, so each path that clears it is observed on its own.

// File: rtl/scsi_cmd_pkg.sv
package scsi_cmd_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned CNT_W   = 2 * REG_W;
  localparam int unsigned LEN_W   = CNT_W + 1;
  localparam int unsigned OP_W    = REG_W - 1;
  localparam int unsigned DMA_BIT = REG_W - 1;
  localparam int unsigned ST_TC   = 4;
  localparam int unsigned QUIET_BIT = 6;

  localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'h0;
  localparam logic [ADDR_W-1:0] A_CNT_MID = 4'h1;
  localparam logic [ADDR_W-1:0] A_CMD     = 4'h3;
  localparam logic [ADDR_W-1:0] A_CFG     = 4'h8;

  localparam logic [REG_W-1:0] INT_FC  = 8'h08;
  localparam logic [REG_W-1:0] INT_BS  = 8'h10;
  localparam logic [REG_W-1:0] INT_DC  = 8'h20;
  localparam logic [REG_W-1:0] INT_RST = 8'h80;
  localparam logic [2:0]       PH_MSG_IN = 3'h7;

  typedef enum logic [OP_W-1:0] {
    OP_NOP      = 7'h00, OP_FLUSH    = 7'h01, OP_CHIP_RST = 7'h02,
    OP_BUS_RST  = 7'h03, OP_XFER     = 7'h10, OP_RESP     = 7'h11,
    OP_MSG_OK   = 7'h12, OP_PAD      = 7'h18, OP_ATN      = 7'h1A,
    OP_SEL      = 7'h41, OP_SEL_ATN  = 7'h42, OP_SEL_STOP = 7'h43,
    OP_SEL_EN   = 7'h44
  } op_e;

  typedef struct packed {
    logic flush, chip_rst, bus_rst, xfer, resp, msg_ok, pad, sel, sel_atn, sel_stop, sel_en;
  } dec_t;

  typedef struct packed {
    logic chip_rst, xfer, sel, sel_atn, sel_stop, resp, illegal;
  } strb_t;

  typedef struct packed {
    logic [REG_W-2:0] stat;
    logic [REG_W-1:0] intr;
    logic [REG_W-1:0] rd_lo, rd_mid, wr_lo, wr_mid;
    logic quiet, dma, irq;
  } regs_t;

  localparam regs_t REGS_RST = '0;
endpackage

// File: rtl/scsi_cmd_opdec.sv
module scsi_cmd_opdec
  import scsi_cmd_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output dec_t            dec_o,
  output logic            legal_o
);
  always_comb begin
    dec_o   = '0;
    legal_o = 1'b1;
    case (op_i)
      OP_NOP, OP_ATN: ;
      OP_FLUSH:    dec_o.flush    = 1'b1;
      OP_CHIP_RST: dec_o.chip_rst = 1'b1;
      OP_BUS_RST:  dec_o.bus_rst  = 1'b1;
      OP_XFER:     dec_o.xfer     = 1'b1;
      OP_RESP:     dec_o.resp     = 1'b1;
      OP_MSG_OK:   dec_o.msg_ok   = 1'b1;
      OP_PAD:      dec_o.pad      = 1'b1;
      OP_SEL:      dec_o.sel      = 1'b1;
      OP_SEL_ATN:  dec_o.sel_atn  = 1'b1;
      OP_SEL_STOP: dec_o.sel_stop = 1'b1;
      OP_SEL_EN:   dec_o.sel_en   = 1'b1;
      default:     legal_o        = 1'b0;
    endcase
  end
endmodule

// File: rtl/scsi_cmd_len.sv
module scsi_cmd_len #(
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0] cnt_i,
  output logic [CW:0]   len_o
);
  localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};
  assign len_o = (cnt_i == '0) ? FULL : {1'b0, cnt_i};
endmodule

// File: rtl/scsi_cmd_state.sv
module scsi_cmd_state
  import scsi_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_lo_we_i,
  input  logic             cnt_mid_we_i,
  input  logic             cfg_we_i,
  input  logic             cmd_we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  dec_t             dec_i,
  input  logic             legal_i,
  input  logic             dma_done_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_eff_o,
  output regs_t            regs_o,
  output logic [LEN_W-1:0] len_o,
  output strb_t            strb_o
);
  regs_t            q, nx;
  logic [LEN_W-1:0] len_q, len_nx;
  strb_t            st_q, st_nx;
  logic             dma_bit;

  assign dma_bit = wdata_i[DMA_BIT];

  // count seen by a transfer command: reloaded copy, or readable copy after any completion
  always_comb begin
    if (dma_bit)         cnt_eff_o = {q.wr_mid, q.wr_lo};
    else if (dma_done_i) cnt_eff_o = '0;
    else                 cnt_eff_o = {q.rd_mid, q.rd_lo};
  end

  always_comb begin
    nx     = q;
    len_nx = len_q;
    st_nx  = '0;
    if (dma_done_i) begin
      nx.stat[ST_TC] = 1'b1;
      nx.intr        = INT_BS;
      nx.rd_lo       = '0;
      nx.rd_mid      = '0;
      nx.irq         = 1'b1;
    end
    if (cnt_lo_we_i) begin
      nx.wr_lo       = wdata_i;
      nx.stat[ST_TC] = 1'b0;
    end
    if (cnt_mid_we_i) begin
      nx.wr_mid      = wdata_i;
      nx.stat[ST_TC] = 1'b0;
    end
    if (cfg_we_i) nx.quiet = wdata_i[QUIET_BIT];
    if (cmd_we_i) begin
      if (!legal_i) begin
        st_nx.illegal = 1'b1;
      end else if (dec_i.chip_rst) begin
        nx             = REGS_RST;
        len_nx         = '0;
        st_nx.chip_rst = 1'b1;
      end else begin
        nx.dma = dma_bit;
        if (dma_bit) begin
          nx.rd_lo  = q.wr_lo;
          nx.rd_mid = q.wr_mid;
        end
        if (dec_i.flush) nx.intr = INT_FC;
        if (dec_i.bus_rst) begin
          nx.intr = INT_RST;
          if (!q.quiet) nx.irq = 1'b1;
        end
        if (dec_i.xfer) begin
          if (dma_bit) nx.stat[ST_TC] = 1'b0;
          len_nx     = len_i;
          st_nx.xfer = 1'b1;
        end
        if (dec_i.resp) begin
          nx.intr      = INT_FC;
          nx.stat[2:0] = PH_MSG_IN;
          st_nx.resp   = 1'b1;
        end
        if (dec_i.msg_ok) begin
          nx.intr = INT_DC;
          nx.irq  = 1'b1;
        end
        if (dec_i.pad) begin
          nx.stat = 7'h10;
          nx.intr = INT_FC;
        end
        if (dec_i.sel_en) nx.intr = '0;
        st_nx.sel      = dec_i.sel;
        st_nx.sel_atn  = dec_i.sel_atn;
        st_nx.sel_stop = dec_i.sel_stop;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q     <= REGS_RST;
      len_q <= '0;
      st_q  <= '0;
    end else begin
      q     <= nx;
      len_q <= len_nx;
      st_q  <= st_nx;
    end
  end

  assign regs_o = q;
  assign len_o  = len_q;
  assign strb_o = st_q;
endmodule

// File: rtl/scsi_cmd_dec.sv
module scsi_cmd_dec
  import scsi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              dma_done_i,
  output logic [REG_W-1:0]  status_o,
  output logic [REG_W-1:0]  intr_o,
  output logic [REG_W-1:0]  cnt_lo_o,
  output logic [REG_W-1:0]  cnt_mid_o,
  output logic              dma_mode_o,
  output logic              irq_o,
  output logic [LEN_W-1:0]  xfer_len_o,
  output logic              chip_rst_o,
  output logic              xfer_start_o,
  output logic              sel_o,
  output logic              sel_atn_o,
  output logic              sel_stop_o,
  output logic              resp_o,
  output logic              illegal_o
);
  dec_t             dec;
  logic             legal;
  logic [CNT_W-1:0] cnt_eff;
  logic [LEN_W-1:0] len_eff;
  regs_t            regs;
  strb_t            strb;

  scsi_cmd_opdec u_opdec (
    .op_i    (wr_data_i[OP_W-1:0]),
    .dec_o   (dec),
    .legal_o (legal)
  );

  scsi_cmd_len #(.CW(CNT_W)) u_len (
    .cnt_i (cnt_eff),
    .len_o (len_eff)
  );

  scsi_cmd_state u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnt_lo_we_i  (wr_en_i && wr_addr_i == A_CNT_LO),
    .cnt_mid_we_i (wr_en_i && wr_addr_i == A_CNT_MID),
    .cfg_we_i     (wr_en_i && wr_addr_i == A_CFG),
    .cmd_we_i     (wr_en_i && wr_addr_i == A_CMD),
    .wdata_i      (wr_data_i),
    .dec_i        (dec),
    .legal_i      (legal),
    .dma_done_i   (dma_done_i),
    .len_i        (len_eff),
    .cnt_eff_o    (cnt_eff),
    .regs_o       (regs),
    .len_o        (xfer_len_o),
    .strb_o       (strb)
  );

  assign status_o     = {regs.irq, regs.stat};
  assign intr_o       = regs.intr;
  assign cnt_lo_o     = regs.rd_lo;
  assign cnt_mid_o    = regs.rd_mid;
  assign dma_mode_o   = regs.dma;
  assign irq_o        = regs.irq;
  assign chip_rst_o   = strb.chip_rst;
  assign xfer_start_o = strb.xfer;
  assign sel_o        = strb.sel;
  assign sel_atn_o    = strb.sel_atn;
  assign sel_stop_o   = strb.sel_stop;
  assign resp_o       = strb.resp;
  assign illegal_o    = strb.illegal;
endmodule

// File: rtl/scsi_cmd_dec_chk.sv
module scsi_cmd_dec_chk
  import scsi_cmd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [REG_W-1:0]  wr_data_i,
  input logic              dma_done_i,
  input logic [REG_W-1:0]  status_o,
  input logic [REG_W-1:0]  intr_o,
  input logic [REG_W-1:0]  cnt_lo_o,
  input logic [REG_W-1:0]  cnt_mid_o,
  input logic              dma_mode_o,
  input logic              irq_o,
  input logic [LEN_W-1:0]  xfer_len_o,
  input logic              chip_rst_o,
  input logic              xfer_start_o,
  input logic              sel_o,
  input logic              sel_atn_o,
  input logic              sel_stop_o,
  input logic              resp_o,
  input logic              illegal_o
);
  logic [6:0] strobes;
  logic       cmd_wr;
  assign strobes = {chip_rst_o, xfer_start_o, sel_o, sel_atn_o, sel_stop_o, resp_o, illegal_o};
  assign cmd_wr  = wr_en_i && wr_addr_i == A_CMD;

  a_r14_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobes));

  a_r14_strobe_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|strobes) |-> $past(cmd_wr));

  a_r2_dma_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_mode_o) |-> $past(cmd_wr && wr_data_i[DMA_BIT]));

  a_r9_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> (xfer_len_o != '0 && xfer_len_o <= 17'h10000));

  a_r13_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dma_done_i && !cmd_wr) |-> (irq_o && intr_o == INT_BS && cnt_lo_o == '0 && cnt_mid_o == '0));

  a_r12_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o && !$past(dma_done_i)) |-> ($stable(intr_o) && $stable(status_o) && $stable(dma_mode_o)));

  a_r5_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(dma_done_i || (cmd_wr &&
      (wr_data_i[OP_W-1:0] == OP_BUS_RST || wr_data_i[OP_W-1:0] == OP_MSG_OK))));

  a_r6_status_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[REG_W-1] == irq_o);
endmodule

bind scsi_cmd_dec scsi_cmd_dec_chk u_chk (.*);

// File: tb/sim_scsi_cmd_dec.sv
`timescale 1ns/1ps
module sim_scsi_cmd_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        dma_done = 1'b0;
  logic [7:0]  status, intr, cnt_lo, cnt_mid;
  logic        dma_mode, irq;
  logic [16:0] xfer_len;
  logic        chip_rst, xfer_start, sel, sel_atn, sel_stop, resp, illegal;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  scsi_cmd_dec u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .dma_done_i(dma_done), .status_o(status), .intr_o(intr), .cnt_lo_o(cnt_lo),
    .cnt_mid_o(cnt_mid), .dma_mode_o(dma_mode), .irq_o(irq), .xfer_len_o(xfer_len),
    .chip_rst_o(chip_rst), .xfer_start_o(xfer_start), .sel_o(sel), .sel_atn_o(sel_atn),
    .sel_stop_o(sel_stop), .resp_o(resp), .illegal_o(illegal)
  );

  function automatic logic [6:0] strobes();
    return {chip_rst, xfer_start, sel, sel_atn, sel_stop, resp, illegal};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one write, returns in the cycle the result is visible
  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmd(logic [7:0] d);
    wr(4'h3, d);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h00);
    chk("R1 intr", intr, 8'h00);
    chk("R1 cnt", {cnt_mid, cnt_lo}, 16'h0);
    chk("R1 dma/irq", {dma_mode, irq}, 2'b00);
    chk("R1 len", xfer_len, 17'h0);
    chk("R1 strobes", strobes(), 7'h0);
  endtask

  task automatic t_chip_reset();
    wr(4'h0, 8'h55); cmd(8'h80); cmd(8'h03);
    chk("R1 pre irq", irq, 1'b1);
    cmd(8'h82);
    chk("R1 chip_rst strobe", strobes(), 7'b1000000);
    chk("R1 status", status, 8'h00);
    chk("R1 intr", intr, 8'h00);
    chk("R1 dma cleared", dma_mode, 1'b0);
    chk("R1 cnt cleared", cnt_lo, 8'h00);
    cmd(8'h80);
    chk("R1 written count cleared", cnt_lo, 8'h00);
    idle();
    chk("R14 chip_rst one cycle", chip_rst, 1'b0);
  endtask

  task automatic t_flush();
    cmd(8'h02); cmd(8'h01);
    chk("R4 intr", intr, 8'h08);
    chk("R4 irq stays low", irq, 1'b0);
    cmd(8'h12); cmd(8'h01);
    chk("R4 intr after msg", intr, 8'h08);
    chk("R4 irq stays high", irq, 1'b1);
  endtask

  task automatic t_bus_reset();
    cmd(8'h02); cmd(8'h03);
    chk("R5 intr", intr, 8'h80);
    chk("R5 irq raised", irq, 1'b1);
    cmd(8'h02); wr(4'h8, 8'h40); cmd(8'h03);
    chk("R5 intr quiet", intr, 8'h80);
    chk("R5 irq suppressed", irq, 1'b0);
    wr(4'h8, 8'hBF); cmd(8'h03);
    chk("R5 irq after quiet cleared", irq, 1'b1);
  endtask

  task automatic t_msg();
    cmd(8'h02); cmd(8'h12);
    chk("R6 intr", intr, 8'h20);
    chk("R6 irq", irq, 1'b1);
    chk("R6 status bit7", status, 8'h80);
  endtask

  task automatic t_pad_and_count();
    cmd(8'h02); cmd(8'h18);
    chk("R7 status", status, 8'h10);
    chk("R7 intr", intr, 8'h08);
    wr(4'h0, 8'h21);
    chk("R3 tc cleared by count write", status, 8'h00);
    chk("R3 readable count unchanged", cnt_lo, 8'h00);
    cmd(8'h18); wr(4'h1, 8'h09);
    chk("R3 tc cleared by mid write", status, 8'h00);
    chk("R3 readable mid unchanged", cnt_mid, 8'h00);
  endtask

  task automatic t_ensel();
    cmd(8'h02); cmd(8'h12); cmd(8'h44);
    chk("R8 intr cleared", intr, 8'h00);
    chk("R8 irq kept", irq, 1'b1);
  endtask

  task automatic t_xfer();
    cmd(8'h02);
    wr(4'h0, 8'h34); wr(4'h1, 8'h12);
    chk("R3 no reload before command", {cnt_mid, cnt_lo}, 16'h0000);
    cmd(8'h90);
    chk("R9 xfer_start", strobes(), 7'b0100000);
    chk("R9 len dma", xfer_len, 17'h01234);
    chk("R2 reload", {cnt_mid, cnt_lo}, 16'h1234);
    chk("R2 dma set", dma_mode, 1'b1);
    idle();
    chk("R14 xfer_start one cycle", xfer_start, 1'b0);
    wr(4'h0, 8'h00); wr(4'h1, 8'h00);
    cmd(8'h10);
    chk("R9 len non-dma uses readable", xfer_len, 17'h01234);
    chk("R2 dma cleared", dma_mode, 1'b0);
    chk("R2 counts kept", {cnt_mid, cnt_lo}, 16'h1234);
    cmd(8'h90);
    chk("R9 zero means 65536", xfer_len, 17'h10000);
    cmd(8'h18); cmd(8'h90);
    chk("R9 dma clears tc", status, 8'h00);
    cmd(8'h18); cmd(8'h10);
    chk("R9 non-dma keeps tc", status, 8'h10);
  endtask

  task automatic t_resp();
    cmd(8'h02); cmd(8'h11);
    chk("R10 resp strobe", strobes(), 7'b0000010);
    chk("R10 intr", intr, 8'h08);
    chk("R10 status phase", status, 8'h07);
  endtask

  task automatic t_sel();
    cmd(8'h02); cmd(8'h41);
    chk("R11 sel", strobes(), 7'b0010000);
    cmd(8'h42);
    chk("R11 sel_atn", strobes(), 7'b0001000);
    cmd(8'h43);
    chk("R11 sel_stop", strobes(), 7'b0000100);
    cmd(8'h12); cmd(8'h1A);
    chk("R11 atn strobes", strobes(), 7'h0);
    chk("R11 atn regs", {status, intr}, 16'h8020);
    cmd(8'h00);
    chk("R11 nop regs", {status, intr}, 16'h8020);
    chk("R11 nop strobes", strobes(), 7'h0);
  endtask

  task automatic t_illegal();
    cmd(8'h02); cmd(8'h80); cmd(8'h12);
    cmd(8'h05);
    chk("R12 illegal strobe", strobes(), 7'b0000001);
    chk("R12 dma unchanged", dma_mode, 1'b0);
    chk("R12 regs unchanged", {status, intr}, 16'h8020);
    cmd(8'h80); wr(4'h0, 8'h77); cmd(8'hFF);
    chk("R12 dma kept", dma_mode, 1'b1);
    chk("R12 count not reloaded", cnt_lo, 8'h00);
  endtask

  task automatic t_dma_done();
    cmd(8'h02); wr(4'h0, 8'h05); cmd(8'h90);
    chk("R13 pre count", cnt_lo, 8'h05);
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    chk("R13 status", status, 8'h90);
    chk("R13 intr", intr, 8'h10);
    chk("R13 count cleared", {cnt_mid, cnt_lo}, 16'h0);
    chk("R13 irq", irq, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chip_reset();
    t_flush();
    t_bus_reset();
    t_msg();
    t_pad_and_count();
    t_ensel();
    t_xfer();
    t_resp();
    t_sel();
    t_illegal();
    t_dma_done();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule